// File: doc/BRIEF.md
# Gated Serial Line Front End

This block is the bit-level front end of a fast serial channel. The transmit half takes bytes from a small local FIFO and shifts them onto a single data line. The receive half samples a data line and assembles bytes for the receive side. Each half runs only on its own line clock, which an external transceiver supplies. That clock may have missing edges. Frame-level protocol work and moving data between clock domains belong to neighbouring blocks.

An external transceiver can stop either direction at any moment with a per-direction gate input. On the transmit side, a gated cycle holds the line at idle '1' and freezes the bit position. When the gate opens again there is a fixed one-clock delay before data resumes. On the receive side, a gated cycle discards whatever is on the line. Frames are delimited by an end marker written with the last byte. A new frame starts only when the FIFO holds enough bytes or already holds a complete frame, which prevents an underrun in the first bytes. If the FIFO still runs dry mid-frame, the block raises a one-cycle underrun pulse, idles the line and discards the rest of that frame. The transmitter can also output a copy of its line clock that is in phase with the data.

Top module: `gated_serial_port`

## Requirements
- R1: Bytes leave on `txd` least significant bit first. While the transmit gate is inactive, the bytes of one frame follow each other with no idle bit between them.
- R2: When `tx_gate` is sampled high at a `tx_clk` edge, `txd` is '1' after the following edge and stays '1' for as long as the gate stays high. The bit position is frozen, and transmission later resumes with the first bit that was not yet sent.
- R3: When `tx_gate` is first sampled low at edge k, `txd` is still '1' after edge k. The first pending data bit appears after edge k+1.
- R4: An idle transmitter starts a frame only when the FIFO is non-empty and holds either at least `tx_start_level` bytes or a byte written with `tx_wr_last`=1. Until then `txd` stays '1'.
- R5: A non-final byte may finish its bit 7 on an open-gate edge while the FIFO is empty. In that case `tx_underrun` is high for exactly one cycle after that edge, and `txd` is '1' from the next edge on. Every byte that follows is discarded, up to and including the next byte marked with `tx_wr_last`=1. Only after that can a new frame start.
- R6: After bit 7 of a byte marked with `tx_wr_last`=1, `txd` returns to '1` and no underrun is raised.
- R7: A bit on `rxd` is accepted at an `rx_clk` edge only if `rx_gate` is low at that same edge. Bits seen while the gate is high are dropped.
- R8: After 8 accepted bits, `rx_data` holds them with the first accepted bit in bit 0. `rx_valid` is set on the `rx_clk` edge after the one that sampled the 8th bit, and stays high for exactly one `rx_clk` cycle.
- R9: A pause in `rx_clk` in the middle of a byte neither loses nor duplicates a bit, and produces no output while the clock is stopped.
- R10: `tx_line_clk` follows `tx_clk` while the registered `tx_clk_out_en` is '1'. It is held at '0' while that enable is '0'. The enable is registered on the rising edge of `tx_clk`.
- R11: During reset and directly after it, `txd` is '1', `tx_underrun` is '0', `rx_valid` is '0' and the transmit FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit line clock (may gap) |
| tx_rst | input | 1 | Synchronous active-high reset, transmit side |
| tx_wr_en | input | 1 | Write a byte into the transmit FIFO |
| tx_wr_data | input | DATA_W | Byte to write |
| tx_wr_last | input | 1 | Marks the written byte as the last of its frame |
| tx_start_level | input | LVL_W | Fill level needed to start a frame |
| tx_fifo_full | output | 1 | FIFO full; writes are dropped while high |
| tx_gate | input | 1 | Transmit gate, high pauses data |
| tx_clk_out_en | input | 1 | Enable for the in-phase clock output |
| txd | output | 1 | Serial transmit data, idle '1' |
| tx_line_clk | output | 1 | Transmit clock copy, in phase with txd |
| tx_underrun | output | 1 | One-cycle pulse on FIFO underrun mid-frame |
| rx_clk | input | 1 | Receive line clock (may gap) |
| rx_rst | input | 1 | Synchronous active-high reset, receive side |
| rxd | input | 1 | Serial receive data |
| rx_gate | input | 1 | Receive gate, high drops the line bit |
| rx_data | output | DATA_W | Assembled received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The hardest state to reach is a transmit frame that is already loaded and then frozen in mid-byte. To get there, the bench fills the FIFO while the gate is held high, so the first byte sits in the shifter without moving. It then opens and closes the gate on chosen cycles and follows the expected bit index edge by edge. It counts two edges of gate latency before each expected change. The underrun-and-discard path is reached by writing a single unmarked byte with a start level of one. Trailing bytes are then written and must never appear on the line. A receive clock gap is made by stopping the bench clock to the receiver between two bits of a byte.

// File: rtl/gsp_pkg.sv
`timescale 1ns/1ps
package gsp_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_SHIFT = 2'd1,
    TX_DRAIN = 2'd2
  } tx_state_t;
endpackage

// File: rtl/gsp_fifo.sv
`timescale 1ns/1ps
// Show-ahead FIFO; the MSB of each word is a frame-end mark, and the FIFO
// keeps a count of marked words currently stored.
module gsp_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic [LW-1:0]    level,
  output logic [LW-1:0]    marks
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [LW-1:0]    cnt, mcnt;
  logic             do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == LW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_data = mem[rptr];
  assign level = cnt;
  assign marks = mcnt;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      mcnt <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      mcnt <= mcnt + LW'(do_wr && wr_data[WIDTH-1])
                   - LW'(do_rd && rd_data[WIDTH-1]);
    end
  end
endmodule

// File: rtl/gsp_tx_serializer.sv
`timescale 1ns/1ps
module gsp_tx_serializer
  import gsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 5,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate_in,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_last,
  input  logic              fifo_empty,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [LVL_W-1:0]  fifo_marks,
  input  logic [LVL_W-1:0]  start_level,
  output logic              pop,
  output logic              txd,
  output logic              underrun
);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  tx_state_t         state;
  logic              gate_q;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     bitpos;
  logic              last_q;
  logic              start_ok, shift_now, byte_end;

  assign start_ok  = !fifo_empty &&
                     ((fifo_level >= start_level) || (fifo_marks != '0));
  assign shift_now = (state == TX_SHIFT) && !gate_q;
  assign byte_end  = shift_now && (bitpos == LAST_BIT);

  always_comb begin
    pop = 1'b0;
    case (state)
      TX_IDLE:  pop = start_ok;
      TX_SHIFT: pop = byte_end && !last_q && !fifo_empty;
      TX_DRAIN: pop = !fifo_empty;
      default:  pop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      gate_q   <= 1'b1;
      shreg    <= '0;
      bitpos   <= '0;
      last_q   <= 1'b0;
      txd      <= 1'b1;
      underrun <= 1'b0;
    end else begin
      gate_q   <= gate_in;
      underrun <= 1'b0;
      case (state)
        TX_IDLE: begin
          txd <= 1'b1;
          if (start_ok) begin
            shreg  <= fifo_data;
            last_q <= fifo_last;
            bitpos <= '0;
            state  <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (gate_q) begin
            txd <= 1'b1;
          end else begin
            txd    <= shreg[0];
            shreg  <= shreg >> 1;
            bitpos <= bitpos + 1'b1;
            if (bitpos == LAST_BIT) begin
              bitpos <= '0;
              if (last_q) begin
                state <= TX_IDLE;
              end else if (!fifo_empty) begin
                shreg  <= fifo_data;
                last_q <= fifo_last;
              end else begin
                underrun <= 1'b1;
                state    <= TX_DRAIN;
              end
            end
          end
        end
        TX_DRAIN: begin
          txd <= 1'b1;
          if (!fifo_empty && fifo_last) state <= TX_IDLE;
        end
        default: begin
          txd   <= 1'b1;
          state <= TX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/gsp_rx_deserializer.sv
`timescale 1ns/1ps
module gsp_rx_deserializer #(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              gate_in,
  output logic [DATA_W-1:0] data_out,
  output logic              valid_out
);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic              rxd_q, gate_q;
  logic [DATA_W-1:0] shreg, next_sh;
  logic [CW-1:0]     bitpos;

  assign next_sh = {rxd_q, shreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_q     <= 1'b1;
      gate_q    <= 1'b1;
      shreg     <= '0;
      bitpos    <= '0;
      data_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      rxd_q     <= rxd;
      gate_q    <= gate_in;
      valid_out <= 1'b0;
      if (!gate_q) begin
        shreg <= next_sh;
        if (bitpos == LAST_BIT) begin
          bitpos    <= '0;
          data_out  <= next_sh;
          valid_out <= 1'b1;
        end else begin
          bitpos <= bitpos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gsp_lineclk.sv
`timescale 1ns/1ps
module gsp_lineclk (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_out
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  assign clk_out = clk & en_q;
endmodule

// File: rtl/gated_serial_port.sv
`timescale 1ns/1ps
module gated_serial_port #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              tx_clk,
  input  logic              tx_rst,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  input  logic              tx_wr_last,
  input  logic [LVL_W-1:0]  tx_start_level,
  output logic              tx_fifo_full,
  input  logic              tx_gate,
  input  logic              tx_clk_out_en,
  output logic              txd,
  output logic              tx_line_clk,
  output logic              tx_underrun,
  input  logic              rx_clk,
  input  logic              rx_rst,
  input  logic              rxd,
  input  logic              rx_gate,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  logic [DATA_W:0]   fifo_rd;
  logic              fifo_empty, fifo_pop;
  logic [LVL_W-1:0]  fifo_level, fifo_marks;

  gsp_fifo #(
    .WIDTH (DATA_W + 1),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk     (tx_clk),
    .rst     (tx_rst),
    .wr_en   (tx_wr_en),
    .wr_data ({tx_wr_last, tx_wr_data}),
    .rd_en   (fifo_pop),
    .rd_data (fifo_rd),
    .empty   (fifo_empty),
    .full    (tx_fifo_full),
    .level   (fifo_level),
    .marks   (fifo_marks)
  );

  gsp_tx_serializer #(
    .DATA_W (DATA_W),
    .LVL_W  (LVL_W)
  ) u_tx (
    .clk         (tx_clk),
    .rst         (tx_rst),
    .gate_in     (tx_gate),
    .fifo_data   (fifo_rd[DATA_W-1:0]),
    .fifo_last   (fifo_rd[DATA_W]),
    .fifo_empty  (fifo_empty),
    .fifo_level  (fifo_level),
    .fifo_marks  (fifo_marks),
    .start_level (tx_start_level),
    .pop         (fifo_pop),
    .txd         (txd),
    .underrun    (tx_underrun)
  );

  gsp_lineclk u_clkout (
    .clk     (tx_clk),
    .rst     (tx_rst),
    .en      (tx_clk_out_en),
    .clk_out (tx_line_clk)
  );

  gsp_rx_deserializer #(
    .DATA_W (DATA_W)
  ) u_rx (
    .clk       (rx_clk),
    .rst       (rx_rst),
    .rxd       (rxd),
    .gate_in   (rx_gate),
    .data_out  (rx_data),
    .valid_out (rx_valid)
  );
endmodule

// File: rtl/gsp_checker.sv
`timescale 1ns/1ps
module gsp_checker (
  input logic tx_clk,
  input logic tx_rst,
  input logic tx_gate,
  input logic txd,
  input logic tx_underrun,
  input logic rx_clk,
  input logic rx_rst,
  input logic rx_gate,
  input logic rx_valid
);
  AST_TX_GATED_IDLE: assert property (@(posedge tx_clk) disable iff (tx_rst)
    $past(tx_gate, 2) |-> txd); // R2

  AST_UNDERRUN_PULSE: assert property (@(posedge tx_clk) disable iff (tx_rst)
    tx_underrun |=> !tx_underrun); // R5

  AST_NO_UNDERRUN_GATED: assert property (@(posedge tx_clk) disable iff (tx_rst)
    $past(tx_gate, 2) |-> !tx_underrun); // R5

  AST_RX_GATED_HOLD: assert property (@(posedge rx_clk) disable iff (rx_rst)
    $past(rx_gate, 2) |-> !rx_valid); // R7

  AST_RX_VALID_PULSE: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_valid |=> !rx_valid); // R8
endmodule

bind gated_serial_port gsp_checker u_chk (
  .tx_clk      (tx_clk),
  .tx_rst      (tx_rst),
  .tx_gate     (tx_gate),
  .txd         (txd),
  .tx_underrun (tx_underrun),
  .rx_clk      (rx_clk),
  .rx_rst      (rx_rst),
  .rx_gate     (rx_gate),
  .rx_valid    (rx_valid)
);

// File: tb/gated_serial_port_test.sv
`timescale 1ns/1ps
module gated_serial_port_test;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  // {data byte, gate mask}: mask bit i inserts one gated cycle before data bit i
  localparam logic [15:0] RX_VEC [6] = '{
    16'hA5_00, 16'h3C_81, 16'h01_FF, 16'h80_10, 16'hF0_0F, 16'h5A_24
  };

  logic clk = 1'b0;
  logic rx_run = 1'b1;
  logic rst = 1'b1;
  logic rx_clk;
  logic wr_en = 1'b0, wr_last = 1'b0, tx_gate = 1'b1, clk_out_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] start_level = LW'(1);
  logic rxd = 1'b1, rx_gate = 1'b1;
  logic fifo_full, txd, tx_line_clk, tx_underrun, rx_valid;
  logic [DW-1:0] rx_data;

  int tests = 0, fails = 0, rx_n = 0, und_n = 0;
  bit done = 1'b0;
  logic [DW-1:0] rx_got [64];

  always #2.5 clk = ~clk;
  assign rx_clk = clk & rx_run;

  gated_serial_port #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) uut (
    .tx_clk(clk), .tx_rst(rst), .tx_wr_en(wr_en), .tx_wr_data(wr_data),
    .tx_wr_last(wr_last), .tx_start_level(start_level), .tx_fifo_full(fifo_full),
    .tx_gate(tx_gate), .tx_clk_out_en(clk_out_en), .txd(txd),
    .tx_line_clk(tx_line_clk), .tx_underrun(tx_underrun),
    .rx_clk(rx_clk), .rx_rst(rst), .rxd(rxd), .rx_gate(rx_gate),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always @(negedge rx_clk) if (!rst && rx_valid) begin
    rx_got[rx_n] = rx_data;
    rx_n++;
  end

  always @(negedge clk) if (!rst && tx_underrun) und_n++;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_last = l;
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  // Sample txd at each negedge; the value seen depends on the gate set two steps earlier.
  task automatic tx_frame(input logic [31:0] bits, input int nb,
                          input logic [31:0] gp, input string tag);
    logic gm2 = 1'b1;
    logic gm1 = 1'b1;
    int idx = 0;
    logic e;
    for (int n = 0; n < nb + 12; n++) begin
      @(negedge clk);
      if (!gm2 && idx < nb) begin e = bits[idx]; idx++; end
      else e = 1'b1;
      check(txd === e, tag, 32'(txd), 32'(e));
      gm2 = gm1;
      gm1 = (n < 32) ? gp[n] : 1'b0;
      tx_gate = gm1;
    end
  endtask

  task automatic rx_send(input logic b, input logic g);
    @(negedge clk);
    rxd = b; rx_gate = g;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R11 txd", 32'(txd), 1);
    check(tx_underrun === 1'b0, "R11 underrun", 32'(tx_underrun), 0);
    check(rx_valid === 1'b0, "R11 rx_valid", 32'(rx_valid), 0);
    check(fifo_full === 1'b0, "R11 full", 32'(fifo_full), 0);
    rst = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R11 txd after release", 32'(txd), 1);

    // R1 R3: frame preloaded under gate, then released
    start_level = LW'(2);
    push(8'h5A, 1'b0);
    push(8'hC3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(txd === 1'b1, "R2 gated loaded frame", 32'(txd), 1);
    end
    tx_frame({16'h0, 8'hC3, 8'h5A}, 16, 32'h0, "R1 R3 R6");

    // R2: freeze mid-byte for four cycles
    tx_gate = 1'b1;
    push(8'h96, 1'b0);
    push(8'h0F, 1'b1);
    repeat (3) @(negedge clk);
    tx_frame({16'h0, 8'h0F, 8'h96}, 16, 32'h0000_0078, "R2");
    check(und_n == 0, "R6 no underrun at frame end", 32'(und_n), 0);

    // R4: threshold holds the start
    tx_gate = 1'b0;
    start_level = LW'(3);
    push(8'h00, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(txd === 1'b1, "R4 below level, one byte", 32'(txd), 1);
    end
    push(8'h00, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(txd === 1'b1, "R4 below level, two bytes", 32'(txd), 1);
    end
    push(8'h01, 1'b1);
    @(negedge clk);
    check(txd === 1'b1, "R4 load cycle", 32'(txd), 1);
    @(negedge clk);
    check(txd === 1'b0, "R4 start at level", 32'(txd), 0);
    repeat (40) @(negedge clk);

    // R4: end marker starts a short frame below the level
    start_level = LW'(8);
    push(8'h02, 1'b1);
    @(negedge clk);
    check(txd === 1'b1, "R4 marker load cycle", 32'(txd), 1);
    @(negedge clk);
    check(txd === 1'b0, "R4 start on marker", 32'(txd), 0);
    repeat (20) @(negedge clk);

    // R5: underrun, discard, recovery
    start_level = LW'(1);
    und_n = 0;
    push(8'h00, 1'b0);
    repeat (8) @(negedge clk);
    @(negedge clk);
    check(txd === 1'b0, "R5 bit7 sent", 32'(txd), 0);
    check(tx_underrun === 1'b1, "R5 underrun pulse", 32'(tx_underrun), 1);
    @(negedge clk);
    check(txd === 1'b1, "R5 line idle", 32'(txd), 1);
    check(tx_underrun === 1'b0, "R5 pulse one cycle", 32'(tx_underrun), 0);
    push(8'h00, 1'b0);
    push(8'h00, 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(txd === 1'b1, "R5 discarded bytes", 32'(txd), 1);
    end
    push(8'h00, 1'b1);
    @(negedge clk);
    check(txd === 1'b1, "R5 recover load", 32'(txd), 1);
    @(negedge clk);
    check(txd === 1'b0, "R5 recover start", 32'(txd), 0);
    repeat (20) @(negedge clk);
    check(und_n == 1, "R5 single underrun", 32'(und_n), 1);

    // R10 line clock output
    @(posedge clk); #1;
    check(tx_line_clk === 1'b0, "R10 disabled high phase", 32'(tx_line_clk), 0);
    @(negedge clk); clk_out_en = 1'b1;
    @(posedge clk); #1;
    check(tx_line_clk === 1'b1, "R10 enabled high phase", 32'(tx_line_clk), 1);
    @(negedge clk); #1;
    check(tx_line_clk === 1'b0, "R10 enabled low phase", 32'(tx_line_clk), 0);
    clk_out_en = 1'b0;
    @(posedge clk); #1;
    check(tx_line_clk === 1'b0, "R10 disabled again", 32'(tx_line_clk), 0);

    // R7 R8: receive vectors with gated cycles
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d, m;
      int base;
      d = RX_VEC[v][15:8];
      m = RX_VEC[v][7:0];
      base = rx_n;
      for (int i = 0; i < 8; i++) begin
        if (m[i]) rx_send(~d[i], 1'b1);
        rx_send(d[i], 1'b0);
      end
      rx_send(1'b0, 1'b1);
      rx_send(1'b0, 1'b1);
      rx_send(1'b0, 1'b1);
      @(negedge clk);
      check(rx_n == base + 1, "R7 one byte per 8 accepted bits", 32'(rx_n - base), 1);
      check(rx_got[base] === d, "R8 byte LSB first", 32'(rx_got[base]), 32'(d));
    end

    // R9: receive clock gap mid-byte
    begin
      logic [7:0] d;
      int base;
      d = 8'h3C;
      base = rx_n;
      for (int i = 0; i < 3; i++) rx_send(d[i], 1'b0);
      @(negedge clk);
      rx_run = 1'b0; rxd = ~d[3];
      repeat (5) @(negedge clk);
      check(rx_n == base, "R9 no output in gap", 32'(rx_n - base), 0);
      rx_run = 1'b1; rxd = d[3]; rx_gate = 1'b0;
      for (int i = 4; i < 8; i++) rx_send(d[i], 1'b0);
      rx_send(1'b0, 1'b1);
      rx_send(1'b0, 1'b1);
      rx_send(1'b0, 1'b1);
      @(negedge clk);
      check(rx_n == base + 1, "R9 one byte across gap", 32'(rx_n - base), 1);
      check(rx_got[base] === d, "R9 byte across gap", 32'(rx_got[base]), 32'(d));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule